// File: doc/BRIEF.md
# Multi-Mode Programmable Logic Cell

This block is one configurable logic cell of the kind tiled inside a small programmable device. Static configuration inputs choose one of three operating modes. Normal mode is a 4-input lookup table. Arithmetic mode splits that table into a 3-input result table and a 3-input carry table. Counter mode turns the cell into one bit of a synchronous up/down counter with enable, load and clear. Every cell also has one storage register. A configuration bit picks whether the cell output comes from the combinational result or from that register.

In normal and arithmetic modes the table result can be ANDed with a cascade input, which builds wide functions across neighbouring cells. Counter mode applies the same AND to the next-count value. A carry output feeds the next cell, so wide adders and counters are built by chaining cells. The clear and load lines are shared across a group of cells. They act on the register only in counter mode, and clear wins over load.

Top module: `plc_cell`

## Requirements
- R1: In mode 2'b00 the result is `cfg_lut_i[idx]`, where `idx = {b3, data_i[2], data_i[1], data_i[0]}` (bit 3 most significant). `b3` is `data_i[3]` when `cfg_cin_sel_i` is 0 and `cin_i` when it is 1.
- R2: When `cfg_casc_en_i` is 1, the combined result is the table output ANDed with `casc_i`. When it is 0, the combined result is the table output alone. The combined result drives `casc_o` in every mode.
- R3: In mode 2'b01 the index is `{cin_i, data_i[1], data_i[0]}`. The result is `cfg_lut_i[idx]` and `cout_o` is `cfg_lut_i[8+idx]`.
- R4: `out_o` is the register value when `cfg_reg_out_i` is 1 and the combined result when it is 0. In modes 00, 01 and 11 the register captures the combined result on every rising clock edge.
- R5: In mode 2'b10 the table index is `{data_i[1] (up), cin_i, q}`. `cout_o` is `cfg_lut_i[8+idx]`. With `data_i[0]` (enable) at 1, the register takes the combined table result. With enable at 0 it holds.
- R6: In mode 2'b10, `sload_i` high loads `data_i[2]` into the register. Load overrides enable and any cascade value.
- R7: In mode 2'b10, `sclr_i` high sets the register to 0. Clear overrides load, enable and cascade.
- R8: Outside mode 2'b10, `sclr_i` and `sload_i` have no effect on the register.
- R9: Mode 2'b11 behaves exactly as mode 2'b00.
- R10: `rst_ni` low clears the register to 0 asynchronously.
- R11: In modes 00 and 11, `cout_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_mode_i | input | 2 | Mode: 00 normal, 01 arithmetic, 10 counter, 11 as normal |
| cfg_lut_i | input | 16 | Lookup table contents; upper half is the carry table in split modes |
| cfg_cin_sel_i | input | 1 | Normal mode: table input 3 from carry-in (1) or data_i[3] (0) |
| cfg_casc_en_i | input | 1 | Enable AND with cascade input |
| cfg_reg_out_i | input | 1 | Output from register (1) or combinational (0) |
| data_i | input | 4 | Data inputs; counter mode: [0] enable, [1] up, [2] load value |
| cin_i | input | 1 | Carry input |
| casc_i | input | 1 | Cascade input, tie to 1 when unused |
| sclr_i | input | 1 | Group-wide synchronous clear |
| sload_i | input | 1 | Group-wide synchronous load |
| out_o | output | 1 | Cell output |
| cout_o | output | 1 | Carry output |
| casc_o | output | 1 | Cascade output |

## Verification
Eight cells are chained through carry and cascade. With full-adder tables, random operand pairs and the all-ones-plus-one corner check that carry propagates through all eight stages. Random tables with random data in normal and reserved modes check that the index bits land in the stated order. Toggling the carry-in select separates the two sources of index bit 3. A running AND along the cascade chain checks the combine. The counter is driven with random enable, direction, load and clear, including clear and load together and wrap-around in both directions. These are compared against an 8-bit reference counter. A load issued while the cascade input is 0 shows that load overrides cascade.

// File: rtl/plc_pkg.sv
package plc_pkg;
  typedef enum logic [1:0] {
    MODE_NORM  = 2'b00,
    MODE_ARITH = 2'b01,
    MODE_COUNT = 2'b10,
    MODE_RSVD  = 2'b11
  } plc_mode_e;
endpackage

// File: rtl/plc_lut_stage.sv
module plc_lut_stage
  import plc_pkg::*;
#(
  parameter int unsigned LUT_INPUTS = 4,
  localparam int unsigned LUT_W = 1 << LUT_INPUTS,
  localparam int unsigned SUB_W = LUT_INPUTS - 1
) (
  input  logic [1:0]            mode_i,
  input  logic [LUT_W-1:0]      lut_i,
  input  logic [LUT_INPUTS-1:0] data_i,
  input  logic                  cin_i,
  input  logic                  cin_sel_i,
  input  logic                  q_i,
  output logic                  f_o,
  output logic                  c_o
);
  logic [LUT_INPUTS-1:0] idx_full;
  logic [SUB_W-1:0]      idx_sub;

  always_comb begin
    idx_full = {cin_sel_i ? cin_i : data_i[LUT_INPUTS-1], data_i[SUB_W-1:0]};
    idx_sub  = '0;
    f_o      = 1'b0;
    c_o      = 1'b0;
    case (mode_i)
      MODE_ARITH: begin
        idx_sub = {cin_i, data_i[SUB_W-2:0]};
        f_o     = lut_i[{1'b0, idx_sub}];
        c_o     = lut_i[{1'b1, idx_sub}];
      end
      MODE_COUNT: begin
        // {up, carry-in, current bit}
        idx_sub = {data_i[1], cin_i, q_i};
        f_o     = lut_i[{1'b0, idx_sub}];
        c_o     = lut_i[{1'b1, idx_sub}];
      end
      default: begin
        f_o = lut_i[idx_full];
        c_o = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/plc_reg_stage.sv
module plc_reg_stage (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic is_count_i,
  input  logic d_i,
  input  logic en_i,
  input  logic clr_i,
  input  logic ld_i,
  input  logic ld_val_i,
  output logic q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         q_o <= 1'b0;
    else if (is_count_i) begin
      if (clr_i)         q_o <= 1'b0;
      else if (ld_i)     q_o <= ld_val_i;
      else if (en_i)     q_o <= d_i;
    end else             q_o <= d_i;
  end

  assert_clr_wins_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_count_i && clr_i) |=> (q_o == 1'b0));
  assert_load_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_count_i && !clr_i && ld_i) |=> (q_o == $past(ld_val_i)));
  assert_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_count_i && !clr_i && !ld_i && !en_i) |=> $stable(q_o));
  assert_follow_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!is_count_i) |=> (q_o == $past(d_i)));
endmodule

// File: rtl/plc_cell.sv
module plc_cell
  import plc_pkg::*;
#(
  parameter int unsigned LUT_INPUTS = 4,
  localparam int unsigned LUT_W = 1 << LUT_INPUTS
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [1:0]            cfg_mode_i,
  input  logic [LUT_W-1:0]      cfg_lut_i,
  input  logic                  cfg_cin_sel_i,
  input  logic                  cfg_casc_en_i,
  input  logic                  cfg_reg_out_i,
  input  logic [LUT_INPUTS-1:0] data_i,
  input  logic                  cin_i,
  input  logic                  casc_i,
  input  logic                  sclr_i,
  input  logic                  sload_i,
  output logic                  out_o,
  output logic                  cout_o,
  output logic                  casc_o
);
  logic f, comb, q, is_count;

  assign is_count = (cfg_mode_i == MODE_COUNT);

  plc_lut_stage #(.LUT_INPUTS(LUT_INPUTS)) u_lut (
    .mode_i    (cfg_mode_i),
    .lut_i     (cfg_lut_i),
    .data_i    (data_i),
    .cin_i     (cin_i),
    .cin_sel_i (cfg_cin_sel_i),
    .q_i       (q),
    .f_o       (f),
    .c_o       (cout_o)
  );

  assign comb   = cfg_casc_en_i ? (f & casc_i) : f;
  assign casc_o = comb;

  plc_reg_stage u_reg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .is_count_i (is_count),
    .d_i        (comb),
    .en_i       (data_i[0]),
    .clr_i      (sclr_i),
    .ld_i       (sload_i),
    .ld_val_i   (data_i[2]),
    .q_o        (q)
  );

  assign out_o = cfg_reg_out_i ? q : comb;

  assert_casc_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_casc_en_i && !casc_i) |-> !casc_o);
  assert_no_carry_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_mode_i == MODE_NORM || cfg_mode_i == MODE_RSVD) |-> !cout_o);
endmodule

// File: tb/plc_cell_bench.sv
`timescale 1ns/1ps
module plc_cell_bench;
  localparam int N = 8;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic [1:0]  mode = 2'b00;
  logic [15:0] lut = 16'h0;
  logic cin_sel = 1'b0, casc_en = 1'b0, reg_out = 1'b1;
  logic cin0 = 1'b0, casc0 = 1'b1, sclr = 1'b0, sload = 1'b0;
  logic [3:0] data_w [N];
  logic [N-1:0] out_w, cout_w, casc_w;
  int n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  for (genvar i = 0; i < N; i++) begin : g_cell
    plc_cell u_plc_cell (
      .clk_i(clk), .rst_ni(rst_ni), .cfg_mode_i(mode), .cfg_lut_i(lut),
      .cfg_cin_sel_i(cin_sel), .cfg_casc_en_i(casc_en), .cfg_reg_out_i(reg_out),
      .data_i(data_w[i]), .cin_i(i == 0 ? cin0 : cout_w[(i == 0) ? 0 : i-1]),
      .casc_i(i == 0 ? casc0 : casc_w[(i == 0) ? 0 : i-1]),
      .sclr_i(sclr), .sload_i(sload),
      .out_o(out_w[i]), .cout_o(cout_w[i]), .casc_o(casc_w[i]));
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [8:0] add_ref(logic [7:0] a, logic [7:0] b, logic c);
    return {1'b0, a} + {1'b0, b} + {8'd0, c};
  endfunction

  task automatic set_adder(logic [7:0] a, logic [7:0] b);
    for (int i = 0; i < N; i++) data_w[i] = {2'b00, b[i], a[i]};
  endtask

  // normal mode chain: cells after the first see carry-in 0 (R11)
  function automatic logic [8:0] norm_ref(logic [15:0] t, logic [31:0] d,
                                          logic sel, logic c0, logic ce, logic k0);
    logic run = k0;
    logic [7:0] o;
    for (int i = 0; i < N; i++) begin
      logic [3:0] dd = d[4*i +: 4];
      logic b3 = sel ? (i == 0 ? c0 : 1'b0) : dd[3];
      logic f = t[{b3, dd[2:0]}];
      o[i] = ce ? (f & run) : f;
      run = o[i];
    end
    return {run, o};
  endfunction

  task automatic cnt_drive(logic en, logic up, logic [7:0] lv, logic c, logic l);
    for (int i = 0; i < N; i++) data_w[i] = {1'b0, lv[i], up, en};
    sclr = c; sload = l;
  endtask

  function automatic logic [7:0] cnt_ref(logic [7:0] q, logic en, logic up,
                                         logic [7:0] lv, logic c, logic l);
    if (c) return 8'h00;
    if (l) return lv;
    if (en) return up ? q + 8'd1 : q - 8'd1;
    return q;
  endfunction

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] q_m;
    void'($urandom(32'h5eed_0c1e));
    for (int i = 0; i < N; i++) data_w[i] = 4'h0;
    repeat (3) @(negedge clk);
    chk("R10 reset", {24'd0, out_w}, 32'd0);
    rst_ni = 1'b1;

    // R3 combinational adder
    mode = 2'b01; lut = 16'hE896; reg_out = 1'b0; casc_en = 1'b0; casc0 = 1'b1;
    for (int k = 0; k < 40; k++) begin
      logic [7:0] a = 8'($urandom), b = 8'($urandom);
      logic c = 1'($urandom);
      if (k == 0) begin a = 8'hFF; b = 8'h01; c = 1'b0; end
      if (k == 1) begin a = 8'hFF; b = 8'h00; c = 1'b1; end
      @(negedge clk); set_adder(a, b); cin0 = c; #2;
      chk("R3 adder", {23'd0, cout_w[N-1], out_w}, {23'd0, add_ref(a, b, c)});
    end

    // R4 registered output, R8 clear/load ignored outside counter mode
    reg_out = 1'b1;
    for (int k = 0; k < 20; k++) begin
      logic [7:0] a = 8'($urandom), b = 8'($urandom);
      logic [8:0] s;
      @(negedge clk); set_adder(a, b); cin0 = 1'b0;
      sclr = 1'($urandom); sload = 1'($urandom);
      s = add_ref(a, b, 1'b0);
      @(negedge clk);
      chk("R4 R8 registered sum", {24'd0, out_w}, {24'd0, s[7:0]});
    end
    sclr = 1'b0; sload = 1'b0;

    // R1 R2 R9 R11 normal / reserved mode with cascade
    reg_out = 1'b0; cin0 = 1'b0;
    for (int k = 0; k < 60; k++) begin
      logic [31:0] d = $urandom;
      logic [8:0] e;
      @(negedge clk);
      mode = (k % 3 == 2) ? 2'b11 : 2'b00;
      lut = (k < 4) ? 16'h8000 : 16'($urandom);
      if (k < 4) d = 32'hFFFF_FFFF;
      cin_sel = 1'($urandom); cin0 = 1'($urandom);
      casc_en = (k >= 10) ? 1'($urandom) : 1'b0;
      casc0 = (k < 4) ? 1'b1 : 1'($urandom);
      for (int i = 0; i < N; i++) data_w[i] = d[4*i +: 4];
      #2;
      e = norm_ref(lut, d, cin_sel, cin0, casc_en, casc0);
      chk(mode == 2'b11 ? "R9 reserved mode out" : "R1 R2 normal out",
          {24'd0, out_w}, {24'd0, e[7:0]});
      chk("R2 cascade out", {31'd0, casc_w[N-1]}, {31'd0, e[7]});
      chk("R11 no carry", {24'd0, cout_w}, 32'd0);
    end

    // counter: R5 R6 R7
    @(negedge clk);
    mode = 2'b10; lut = 16'h8466; reg_out = 1'b1; casc_en = 1'b0;
    casc0 = 1'b1; cin0 = 1'b1; cin_sel = 1'b0;
    cnt_drive(1'b0, 1'b1, 8'h00, 1'b1, 1'b0);
    q_m = 8'h00;
    @(negedge clk);
    chk("R7 initial clear", {24'd0, out_w}, 32'd0);
    for (int k = 0; k < 300; k++) begin
      logic en = ($urandom % 4) != 0, up = 1'($urandom);
      logic [7:0] lv = 8'($urandom);
      logic c = ($urandom % 10) == 0, l = ($urandom % 8) == 0;
      if (k == 20) begin c = 1'b1; l = 1'b1; end
      if (k == 21) begin c = 1'b0; l = 1'b1; lv = 8'hFF; end
      if (k == 22) begin en = 1'b1; up = 1'b1; c = 1'b0; l = 1'b0; end
      if (k == 23) begin en = 1'b1; up = 1'b0; c = 1'b0; l = 1'b0; end
      if (k == 24) begin c = 1'b1; l = 1'b1; lv = 8'hA5; end
      cnt_drive(en, up, lv, c, l);
      q_m = cnt_ref(q_m, en, up, lv, c, l);
      @(negedge clk);
      chk(c ? "R7 clear over load" : (l ? "R6 load" : "R5 count/hold"),
          {24'd0, out_w}, {24'd0, q_m});
    end

    // R6 load overrides a zero cascade; R5 counting takes the cascade AND
    casc_en = 1'b1; casc0 = 1'b0;
    cnt_drive(1'b1, 1'b1, 8'hA5, 1'b0, 1'b1);
    @(negedge clk);
    chk("R6 load over cascade", {24'd0, out_w}, 32'h0000_00A5);
    cnt_drive(1'b1, 1'b1, 8'h00, 1'b0, 1'b0);
    @(negedge clk);
    chk("R5 cascade gated count", {24'd0, out_w}, 32'd0);
    cnt_drive(1'b1, 1'b1, 8'h3C, 1'b0, 1'b1);
    @(negedge clk);
    cnt_drive(1'b1, 1'b1, 8'h3C, 1'b1, 1'b1);
    @(negedge clk);
    chk("R7 clear over cascade and load", {24'd0, out_w}, 32'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule